// File: doc/BRIEF.md
# Logical Device Configuration Register File

This block holds the configuration state of a single logical device that sits on an ISA-style host bus. Software reaches its registers through an index/data pair: one strobe loads an 8-bit index, and a second strobe writes the data byte into the register that the index selects. The selected register is always presented on a read-data output. The stored state is as follows:

- an enable flag for the device;
- a test mode that checks the I/O range;
- a 16-bit I/O base that is aligned to 8 bytes;
- an interrupt level;
- a fixed interrupt-type byte;
- a vendor control register that latches the states of eight host IRQ lines on request and drives a pull-low enable.

Alongside the registers, the block decodes every host I/O cycle against the assigned window. An enabled device gets a chip-select and a 3-bit offset for hits. When the device is disabled and range checking is on, the block itself answers reads inside the window with a fixed pattern, so that software can look for address conflicts. The device's interrupt request goes to a 16-bit one-hot IRQ output at the programmed level.

Top module: `ldev_cfg`

## Requirements
- R1: After reset, the enable, range-check, base, IRQ-level, pull-low and snapshot state are all zero. Reads of indexes 30h, 31h, 60h, 61h, 70h, F1h and F2h return 00h. All bus, select and IRQ outputs are zero.
- R2: A data write goes to the register named by the most recent index write. The written value reads back on cfg_rdata_o, masked per register: 30h keeps bit 0 (enable), 31h keeps bits 1:0, 60h keeps 8 bits (base[15:8]), 61h keeps bits 7:3 (base[7:3]), and 70h keeps bits 3:0 (level).
- R3: A read of any index other than 30h, 31h, 60h, 61h, 70h, 71h, F1h and F2h returns 00h. A write to such an index changes no register.
- R4: Index 71h always reads 02h, and writes to it are ignored.
- R5: While enabled, a host read or write whose address bits [15:3] equal the base raises dev_cs_o and puts address bits [2:0] on dev_ofs_o. In every other case dev_cs_o and dev_ofs_o are zero.
- R6: While disabled with 31h bit 1 set, a host read inside the window drives io_rdata_oe_o high with io_rdata_o = 55h if 31h bit 0 is 1, or AAh if it is 0.
- R7: While enabled, range check has no effect: io_rdata_oe_o stays low even when 31h bit 1 is set.
- R8: For writes, misses, idle cycles, or range check off, io_rdata_oe_o is low and io_rdata_o is 00h.
- R9: A data write to F1h with bit 0 = 1 copies irq_lines_i into F2h at that clock edge. F2h bit k holds the line for IRQ3, 4, 5, 7, 10, 11, 12, 15 for k = 0 to 7. With bit 0 = 0 the snapshot is kept. Bit 0 of F1h reads back as 0.
- R10: pull_low_o equals bit 1 of the last value written to F1h, and F1h bit 1 reads back that value.
- R11: F2h is read-only: writes to it leave the snapshot unchanged.
- R12: irq_o is 1 << level when the device is enabled, the level is nonzero and dev_irq_i is high. Otherwise irq_o is zero, and irq_o has at most one bit set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_idx_wr_i | input | 1 | Load cfg_wdata_i into the index register |
| cfg_dat_wr_i | input | 1 | Write cfg_wdata_i into the indexed register |
| cfg_wdata_i | input | 8 | Index or data byte |
| cfg_rdata_o | output | 8 | Contents of the indexed register |
| io_addr_i | input | 16 | Host I/O address |
| io_rd_i | input | 1 | Host I/O read strobe |
| io_wr_i | input | 1 | Host I/O write strobe |
| io_rdata_o | output | 8 | Range-check response byte |
| io_rdata_oe_o | output | 1 | Drive enable for io_rdata_o |
| dev_cs_o | output | 1 | Device select for a window hit |
| dev_ofs_o | output | 3 | Offset inside the window |
| irq_lines_i | input | 8 | Sampled host IRQ lines (3,4,5,7,10,11,12,15) |
| pull_low_o | output | 1 | Pull-low resistor enable |
| dev_irq_i | input | 1 | Device interrupt request |
| irq_o | output | 16 | One-hot host IRQ output |

## Verification
The checker assumes that the only way to change the snapshot is a data write to F1h with bit 0 set. It also assumes that all strobes are sampled at the rising edge. The window and IRQ properties rest only on the current register state and the current bus inputs, so they hold for any mix of io_rd_i and io_wr_i. The stimulus changes inputs only on the falling edge. It never raises the index and data strobes in the same cycle. It sweeps the bus address around each programmed window, including the lowest and the highest window in the address space.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int WIN_W  = 3;
  localparam int LVL_W  = 4;
  localparam int IRQ_N  = 1 << LVL_W;
  localparam int SNAP_W = 8;
  localparam int BHI_W  = ADDR_W - DATA_W;
  localparam int BLO_W  = DATA_W - WIN_W;

  localparam logic [DATA_W-1:0] IDX_ACT     = 8'h30;
  localparam logic [DATA_W-1:0] IDX_RCHK    = 8'h31;
  localparam logic [DATA_W-1:0] IDX_BASE_HI = 8'h60;
  localparam logic [DATA_W-1:0] IDX_BASE_LO = 8'h61;
  localparam logic [DATA_W-1:0] IDX_IRQ_LVL = 8'h70;
  localparam logic [DATA_W-1:0] IDX_IRQ_TYP = 8'h71;
  localparam logic [DATA_W-1:0] IDX_VCTL    = 8'hF1;
  localparam logic [DATA_W-1:0] IDX_VSNAP   = 8'hF2;

  localparam logic [DATA_W-1:0] IRQ_TYPE_VAL = 8'h02;
  localparam logic [DATA_W-1:0] PAT_SET      = 8'h55;
  localparam logic [DATA_W-1:0] PAT_CLR      = 8'hAA;
endpackage

// File: rtl/ldev_cfg_regs.sv
module ldev_cfg_regs
  import ldev_cfg_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    idx_wr_i,
  input  logic                    dat_wr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [SNAP_W-1:0]       irq_lines_i,
  output logic [DATA_W-1:0]       idx_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    act_o,
  output logic                    rc_en_o,
  output logic                    rc_sel_o,
  output logic [ADDR_W-1:WIN_W]   base_o,
  output logic [LVL_W-1:0]        lvl_o,
  output logic                    pull_o,
  output logic [SNAP_W-1:0]       snap_o
);
  logic [DATA_W-1:0] idx_q;
  logic              act_q, rc_en_q, rc_sel_q, pull_q;
  logic [BHI_W-1:0]  bhi_q;
  logic [BLO_W-1:0]  blo_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [SNAP_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      act_q    <= 1'b0;
      rc_en_q  <= 1'b0;
      rc_sel_q <= 1'b0;
      bhi_q    <= '0;
      blo_q    <= '0;
      lvl_q    <= '0;
      pull_q   <= 1'b0;
      snap_q   <= '0;
    end else begin
      if (idx_wr_i) idx_q <= wdata_i;
      if (dat_wr_i) begin
        case (idx_q)
          IDX_ACT:     act_q <= wdata_i[0];
          IDX_RCHK: begin
            rc_en_q  <= wdata_i[1];
            rc_sel_q <= wdata_i[0];
          end
          IDX_BASE_HI: bhi_q <= wdata_i;
          IDX_BASE_LO: blo_q <= wdata_i[DATA_W-1:WIN_W];
          IDX_IRQ_LVL: lvl_q <= wdata_i[LVL_W-1:0];
          IDX_VCTL: begin
            pull_q <= wdata_i[1];
            if (wdata_i[0]) snap_q <= irq_lines_i;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_q)
      IDX_ACT:     rdata_o[0] = act_q;
      IDX_RCHK:    rdata_o[1:0] = {rc_en_q, rc_sel_q};
      IDX_BASE_HI: rdata_o = bhi_q;
      IDX_BASE_LO: rdata_o = {blo_q, {WIN_W{1'b0}}};
      IDX_IRQ_LVL: rdata_o[LVL_W-1:0] = lvl_q;
      IDX_IRQ_TYP: rdata_o = IRQ_TYPE_VAL;
      IDX_VCTL:    rdata_o[1] = pull_q;  // capture bit self-clears
      IDX_VSNAP:   rdata_o = snap_q;
      default:     rdata_o = '0;
    endcase
  end

  assign idx_o    = idx_q;
  assign act_o    = act_q;
  assign rc_en_o  = rc_en_q;
  assign rc_sel_o = rc_sel_q;
  assign base_o   = {bhi_q, blo_q};
  assign lvl_o    = lvl_q;
  assign pull_o   = pull_q;
  assign snap_o   = snap_q;
endmodule

// File: rtl/ldev_cfg_decode.sv
module ldev_cfg_decode
  import ldev_cfg_pkg::*;
(
  input  logic                  act_i,
  input  logic                  rc_en_i,
  input  logic                  rc_sel_i,
  input  logic [ADDR_W-1:WIN_W] base_i,
  input  logic [ADDR_W-1:0]     io_addr_i,
  input  logic                  io_rd_i,
  input  logic                  io_wr_i,
  output logic                  cs_o,
  output logic [WIN_W-1:0]      ofs_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  oe_o
);
  logic hit, rc_live;

  assign hit     = (io_addr_i[ADDR_W-1:WIN_W] == base_i);
  // range check only answers for a disabled device
  assign rc_live = rc_en_i && !act_i;

  assign cs_o    = hit && act_i && (io_rd_i || io_wr_i);
  assign ofs_o   = cs_o ? io_addr_i[WIN_W-1:0] : '0;
  assign oe_o    = hit && rc_live && io_rd_i;
  assign rdata_o = !oe_o ? '0 : (rc_sel_i ? PAT_SET : PAT_CLR);
endmodule

// File: rtl/ldev_cfg_irq.sv
module ldev_cfg_irq
  import ldev_cfg_pkg::*;
(
  input  logic             act_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             dev_irq_i,
  output logic [IRQ_N-1:0] irq_o
);
  logic en;
  assign en = act_i && dev_irq_i;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    if (g == 0) begin : g_none
      assign irq_o[g] = 1'b0;  // level 0 = unassigned
    end else begin : g_sel
      assign irq_o[g] = en && (lvl_i == LVL_W'(g));
    end
  end
endmodule

// File: rtl/ldev_cfg.sv
module ldev_cfg
  import ldev_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_idx_wr_i,
  input  logic              cfg_dat_wr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              io_rdata_oe_o,
  output logic              dev_cs_o,
  output logic [WIN_W-1:0]  dev_ofs_o,
  input  logic [SNAP_W-1:0] irq_lines_i,
  output logic              pull_low_o,
  input  logic              dev_irq_i,
  output logic [IRQ_N-1:0]  irq_o
);
  logic [DATA_W-1:0]     cfg_idx;
  logic                  act_q, rc_en_q, rc_sel_q;
  logic [ADDR_W-1:WIN_W] base_q;
  logic [LVL_W-1:0]      lvl_q;
  logic [SNAP_W-1:0]     snap_q;

  ldev_cfg_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_wr_i    (cfg_idx_wr_i),
    .dat_wr_i    (cfg_dat_wr_i),
    .wdata_i     (cfg_wdata_i),
    .irq_lines_i (irq_lines_i),
    .idx_o       (cfg_idx),
    .rdata_o     (cfg_rdata_o),
    .act_o       (act_q),
    .rc_en_o     (rc_en_q),
    .rc_sel_o    (rc_sel_q),
    .base_o      (base_q),
    .lvl_o       (lvl_q),
    .pull_o      (pull_low_o),
    .snap_o      (snap_q)
  );

  ldev_cfg_decode i_decode (
    .act_i     (act_q),
    .rc_en_i   (rc_en_q),
    .rc_sel_i  (rc_sel_q),
    .base_i    (base_q),
    .io_addr_i (io_addr_i),
    .io_rd_i   (io_rd_i),
    .io_wr_i   (io_wr_i),
    .cs_o      (dev_cs_o),
    .ofs_o     (dev_ofs_o),
    .rdata_o   (io_rdata_o),
    .oe_o      (io_rdata_oe_o)
  );

  ldev_cfg_irq i_irq (
    .act_i     (act_q),
    .lvl_i     (lvl_q),
    .dev_irq_i (dev_irq_i),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/ldev_cfg_chk.sv
module ldev_cfg_chk
  import ldev_cfg_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_dat_wr_i,
  input logic [DATA_W-1:0]     cfg_wdata_i,
  input logic [DATA_W-1:0]     cfg_idx,
  input logic                  act_q,
  input logic [ADDR_W-1:WIN_W] base_q,
  input logic [SNAP_W-1:0]     snap_q,
  input logic [ADDR_W-1:0]     io_addr_i,
  input logic                  io_rd_i,
  input logic                  io_wr_i,
  input logic                  io_rdata_oe_o,
  input logic [DATA_W-1:0]     io_rdata_o,
  input logic                  dev_cs_o,
  input logic [IRQ_N-1:0]      irq_o
);
  logic cap_req;
  assign cap_req = cfg_dat_wr_i && (cfg_idx == IDX_VCTL) && cfg_wdata_i[0];

  assert_cs_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_cs_o |-> act_q && (io_rd_i || io_wr_i) && (io_addr_i[ADDR_W-1:WIN_W] == base_q));

  assert_rchk_pat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rdata_oe_o |-> (io_rdata_o == PAT_SET) || (io_rdata_o == PAT_CLR));

  assert_rchk_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> !io_rdata_oe_o);

  assert_oe_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rdata_oe_o |-> io_rd_i && !dev_cs_o);

  assert_bus_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rdata_oe_o |-> (io_rdata_o == '0));

  assert_snap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_req |=> $stable(snap_q));

  assert_irq_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  assert_irq_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> act_q && !irq_o[0]);
endmodule

bind ldev_cfg ldev_cfg_chk i_ldev_cfg_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_dat_wr_i  (cfg_dat_wr_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .cfg_idx       (cfg_idx),
  .act_q         (act_q),
  .base_q        (base_q),
  .snap_q        (snap_q),
  .io_addr_i     (io_addr_i),
  .io_rd_i       (io_rd_i),
  .io_wr_i       (io_wr_i),
  .io_rdata_oe_o (io_rdata_oe_o),
  .io_rdata_o    (io_rdata_o),
  .dev_cs_o      (dev_cs_o),
  .irq_o         (irq_o)
);

// File: tb/test_ldev_cfg.sv
`timescale 1ns/1ps
module test_ldev_cfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_idx_wr = 1'b0, cfg_dat_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        io_oe, dev_cs;
  logic [2:0]  dev_ofs;
  logic [7:0]  irq_lines = '0;
  logic        pull_low;
  logic        dev_irq = 1'b0;
  logic [15:0] irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of register state
  bit        m_act, m_rcen, m_rcsel, m_pull;
  bit [7:0]  m_bhi, m_snap;
  bit [4:0]  m_blo;
  bit [3:0]  m_lvl;

  always #2.5 clk = ~clk;

  ldev_cfg i_ldev_cfg (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_idx_wr_i(cfg_idx_wr), .cfg_dat_wr_i(cfg_dat_wr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .io_rdata_o(io_rdata), .io_rdata_oe_o(io_oe),
    .dev_cs_o(dev_cs), .dev_ofs_o(dev_ofs),
    .irq_lines_i(irq_lines), .pull_low_o(pull_low),
    .dev_irq_i(dev_irq), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_reg(input bit [7:0] i);
    case (i)
      8'h30: return {7'b0, m_act};
      8'h31: return {6'b0, m_rcen, m_rcsel};
      8'h60: return m_bhi;
      8'h61: return {m_blo, 3'b0};
      8'h70: return {4'b0, m_lvl};
      8'h71: return 8'h02;
      8'hF1: return {6'b0, m_pull, 1'b0};
      8'hF2: return m_snap;
      default: return 8'h00;
    endcase
  endfunction

  task automatic set_idx(input bit [7:0] i);
    @(negedge clk); cfg_idx_wr = 1'b1; cfg_wdata = i;
    @(negedge clk); cfg_idx_wr = 1'b0; #1;
  endtask

  // write value, update model per the requirements
  task automatic wreg(input bit [7:0] i, input bit [7:0] v);
    set_idx(i);
    @(negedge clk); cfg_dat_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_dat_wr = 1'b0; #1;
    case (i)
      8'h30: m_act = v[0];
      8'h31: begin m_rcen = v[1]; m_rcsel = v[0]; end
      8'h60: m_bhi = v;
      8'h61: m_blo = v[7:3];
      8'h70: m_lvl = v[3:0];
      8'hF1: begin m_pull = v[1]; if (v[0]) m_snap = irq_lines; end
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string req, input bit [7:0] i);
    set_idx(i);
    chk(req, $sformatf("reg %02h", i), cfg_rdata, exp_reg(i));
  endtask

  task automatic sweep_regs(input string req);
    for (int i = 0; i < 256; i++) rd_chk(req, 8'(i));
  endtask

  task automatic io_sweep(input string tag);
    bit [15:0] base;
    base = {m_bhi, m_blo, 3'b0};
    for (int o = -12; o < 20; o++) begin
      for (int s = 0; s < 4; s++) begin
        bit [15:0] a;
        bit hit, ecs, eoe;
        a = base + 16'(o);
        @(negedge clk);
        io_addr = a; io_rd = s[0]; io_wr = s[1];
        #1;
        hit = (a[15:3] == base[15:3]);
        ecs = m_act && hit && (s != 0);
        eoe = !m_act && m_rcen && hit && s[0];
        chk("R5", {tag, " cs"}, dev_cs, ecs);
        chk("R5", {tag, " ofs"}, dev_ofs, ecs ? a[2:0] : 3'd0);
        chk(m_act ? "R7" : (m_rcen ? "R6" : "R8"), {tag, " oe"}, io_oe, eoe);
        chk(eoe ? "R6" : "R8", {tag, " data"}, io_rdata, eoe ? (m_rcsel ? 8'h55 : 8'hAA) : 8'h00);
      end
    end
    @(negedge clk); io_rd = 0; io_wr = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "irq", irq, 0);
    chk("R1", "cs", dev_cs, 0);
    chk("R1", "oe", io_oe, 0);
    chk("R1", "pull", pull_low, 0);
    sweep_regs("R1");

    // R2 write/readback with masks
    wreg(8'h30, 8'hFE); rd_chk("R2", 8'h30);
    wreg(8'h31, 8'hFF); rd_chk("R2", 8'h31);
    wreg(8'h31, 8'h00); rd_chk("R2", 8'h31);
    wreg(8'h60, 8'hA5); rd_chk("R2", 8'h60);
    wreg(8'h61, 8'hFF); rd_chk("R2", 8'h61);
    wreg(8'h70, 8'hF9); rd_chk("R2", 8'h70);

    // R3 undefined writes ignored, R4 71h fixed
    wreg(8'h00, 8'hFF); wreg(8'h32, 8'hFF); wreg(8'h62, 8'hFF); wreg(8'hFF, 8'hFF);
    wreg(8'h71, 8'hFF);
    sweep_regs("R3");
    rd_chk("R4", 8'h71);

    // R5..R8 window decode over modes and bases
    for (int b = 0; b < 3; b++) begin
      bit [15:0] bs;
      bs = (b == 0) ? 16'h0000 : (b == 1) ? 16'h03F8 : 16'hFFF8;
      wreg(8'h60, bs[15:8]); wreg(8'h61, bs[7:0]);
      for (int m = 0; m < 6; m++) begin
        wreg(8'h30, {7'b0, m[2] ^ m[0] & m[1]});
        wreg(8'h31, {6'b0, m[1] | m[2], m[0]});
        io_sweep($sformatf("base=%04h mode=%0d", bs, m));
      end
    end

    // R9/R10/R11 snapshot and pull-low
    wreg(8'h30, 8'h00);
    for (int k = 0; k < 8; k++) begin
      irq_lines = 8'(8'h5A ^ (8'h1 << k));
      wreg(8'hF1, {6'b0, k[0], 1'b1});
      rd_chk("R9", 8'hF2);
      chk("R10", "pull", pull_low, k[0]);
      rd_chk("R10", 8'hF1);
      irq_lines = ~irq_lines;
      wreg(8'hF1, 8'h02);
      rd_chk("R9", 8'hF2);
      wreg(8'hF2, 8'hFF ^ 8'(k));
      rd_chk("R11", 8'hF2);
    end
    wreg(8'hF1, 8'h00);
    chk("R10", "pull off", pull_low, 0);

    // R12 irq routing sweep
    for (int a = 0; a < 2; a++) begin
      wreg(8'h30, 8'(a));
      for (int l = 0; l < 16; l++) begin
        wreg(8'h70, 8'(l));
        for (int d = 0; d < 2; d++) begin
          @(negedge clk); dev_irq = d[0]; #1;
          chk("R12", $sformatf("irq act=%0d lvl=%0d req=%0d", a, l, d), irq,
              (a == 1 && l != 0 && d == 1) ? (32'h1 << l) : 32'h0);
        end
      end
    end
    dev_irq = 0;

    // R1 reset again after programming
    @(negedge clk); rst_n = 1'b0; #1;
    m_act = 0; m_rcen = 0; m_rcsel = 0; m_pull = 0; m_bhi = 0; m_blo = 0; m_lvl = 0; m_snap = 0;
    chk("R1", "pull after reset", pull_low, 0);
    @(negedge clk); rst_n = 1'b1;
    sweep_regs("R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule